// File: doc/BRIEF.md
# Two-Digit Decimal Adder/Subtractor

A purely combinational arithmetic unit for packed decimal numbers. It takes two operands, X and Y. Each operand is two BCD digits, units and tens, with 4 bits per digit. A 2-bit mode input selects one of three operations: X plus Y, X minus Y, or Y minus X. The block returns a two-digit BCD result and one flag. The flag is the decimal carry out when adding and the decimal borrow out when subtracting.

Each digit position is a decimal-corrected cell. When adding, a cell whose binary sum goes above nine adds six and raises a carry. When subtracting, a cell whose minuend is smaller than the subtrahend plus the incoming borrow adds ten and raises a borrow. The carry or borrow ripples from the units cell into the tens cell. If the final borrow is set, the result holds the hundreds complement of the true negative difference. The fourth mode code is reserved and yields zero. Operand digits above nine are outside the contract and their outputs are not specified.

Top module: `bcd_addsub2`

## Requirements
- R1: With mode 0, result is (X+Y) mod 100 in BCD and carry_flag is 1 exactly when X+Y is 100 or more.
- R2: With mode 1 and X >= Y, result is X-Y in BCD and carry_flag is 0.
- R3: With mode 1 and X < Y, carry_flag is 1 and result is 100+X-Y in BCD.
- R4: With mode 2, result and carry_flag follow R2/R3 with the roles of X and Y exchanged (Y-X).
- R5: With mode 3, result is 8'h00 and carry_flag is 0 for any operands.
- R6: Bits [3:0] of each operand and of result carry the units digit and bits [7:4] the tens digit; for legal operands every result digit lies in 0..9.
- R7: A carry or borrow produced in the units digit is applied to the tens digit in the same evaluation (for example 95+05 gives 00 with flag 1, 10-01 gives 09, 00-01 gives 99 with flag 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_x | input | 8 | Operand X, packed BCD, tens in [7:4], units in [3:0] |
| opnd_y | input | 8 | Operand Y, packed BCD, same layout |
| mode | input | 2 | 0 add, 1 X-Y, 2 Y-X, 3 reserved (zero output) |
| result | output | 8 | Packed BCD result, tens in [7:4], units in [3:0] |
| carry_flag | output | 1 | Decimal carry out (mode 0) or borrow out (modes 1, 2) |

## Verification
The in-line assertions test each digit cell on every evaluation with legal inputs. They check that the corrected digit and its outgoing carry or borrow together equal the arithmetic value of that position, and that the digit stays within 0..9. They also check that the reserved mode forces zero at the top. Only the bench can show that the digits are chained in the right order and that operands are swapped correctly for Y-X. It shows this by comparing every legal operand pair, in every mode, against a decimal model.

// File: rtl/bcd_addsub_pkg.sv
`timescale 1ns/1ps
package bcd_addsub_pkg;
  localparam int DIGIT_W = 4;
  localparam int DIGIT_MAX = 9;

  typedef enum logic [1:0] {
    MODE_ADD   = 2'd0,
    MODE_XSUBY = 2'd1,
    MODE_YSUBX = 2'd2,
    MODE_IDLE  = 2'd3
  } mode_e;
endpackage

// File: rtl/bcd_digit_cell.sv
`timescale 1ns/1ps
module bcd_digit_cell #(
  parameter int W = bcd_addsub_pkg::DIGIT_W
) (
  input  logic [W-1:0] dig_a,
  input  logic [W-1:0] dig_b,
  input  logic         cin,
  input  logic         do_sub,
  output logic [W-1:0] dig_o,
  output logic         cout
);
  localparam logic [W:0] LIMIT = (W+1)'(bcd_addsub_pkg::DIGIT_MAX);
  localparam logic [W-1:0] ADD_FIX = W'(6);
  localparam logic [W-1:0] SUB_FIX = W'(10);

  logic [W:0] raw_sum;
  logic [W:0] raw_dif;

  always_comb begin
    raw_sum = {1'b0, dig_a} + {1'b0, dig_b} + {{W{1'b0}}, cin};
    raw_dif = {1'b0, dig_a} - {1'b0, dig_b} - {{W{1'b0}}, cin};
    dig_o   = '0;
    cout    = 1'b0;
    if (do_sub) begin
      if (raw_dif[W]) begin
        dig_o = raw_dif[W-1:0] + SUB_FIX;
        cout  = 1'b1;
      end else begin
        dig_o = raw_dif[W-1:0];
      end
    end else begin
      if (raw_sum > LIMIT) begin
        dig_o = raw_sum[W-1:0] + ADD_FIX;
        cout  = 1'b1;
      end else begin
        dig_o = raw_sum[W-1:0];
      end
    end
  end

  always_comb begin
    if (int'(dig_a) <= bcd_addsub_pkg::DIGIT_MAX && int'(dig_b) <= bcd_addsub_pkg::DIGIT_MAX) begin
      // R1
      if (!do_sub) begin
        digit_add_chk: assert (int'(dig_o) + 10 * int'(cout) == int'(dig_a) + int'(dig_b) + int'(cin));
      end
      // R2
      if (do_sub) begin
        digit_sub_chk: assert (int'(dig_o) - 10 * int'(cout) == int'(dig_a) - int'(dig_b) - int'(cin));
      end
      // R6
      digit_range_chk: assert (int'(dig_o) <= bcd_addsub_pkg::DIGIT_MAX);
    end
  end
endmodule

// File: rtl/bcd_operand_route.sv
`timescale 1ns/1ps
module bcd_operand_route #(
  parameter int VW = 8
) (
  input  logic [VW-1:0] opnd_x,
  input  logic [VW-1:0] opnd_y,
  input  bcd_addsub_pkg::mode_e mode,
  output logic [VW-1:0] lhs,
  output logic [VW-1:0] rhs,
  output logic          do_sub,
  output logic          active
);
  import bcd_addsub_pkg::*;

  always_comb begin
    lhs    = opnd_x;
    rhs    = opnd_y;
    do_sub = 1'b0;
    active = 1'b1;
    unique case (mode)
      MODE_ADD:   ;
      MODE_XSUBY: do_sub = 1'b1;
      MODE_YSUBX: begin
        lhs    = opnd_y;
        rhs    = opnd_x;
        do_sub = 1'b1;
      end
      default:    active = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcd_addsub2.sv
`timescale 1ns/1ps
module bcd_addsub2 #(
  parameter int NDIG = 2
) (
  input  logic [NDIG*bcd_addsub_pkg::DIGIT_W-1:0] opnd_x,
  input  logic [NDIG*bcd_addsub_pkg::DIGIT_W-1:0] opnd_y,
  input  logic [1:0]                              mode,
  output logic [NDIG*bcd_addsub_pkg::DIGIT_W-1:0] result,
  output logic                                    carry_flag
);
  import bcd_addsub_pkg::*;
  localparam int W  = DIGIT_W;
  localparam int VW = NDIG * W;

  logic [VW-1:0] lhs, rhs, raw_res;
  logic          do_sub, active;
  logic [NDIG:0] chain;

  bcd_operand_route #(.VW(VW)) u_route (
    .opnd_x (opnd_x),
    .opnd_y (opnd_y),
    .mode   (mode_e'(mode)),
    .lhs    (lhs),
    .rhs    (rhs),
    .do_sub (do_sub),
    .active (active)
  );

  assign chain[0] = 1'b0;

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    bcd_digit_cell #(.W(W)) u_cell (
      .dig_a  (lhs[g*W +: W]),
      .dig_b  (rhs[g*W +: W]),
      .cin    (chain[g]),
      .do_sub (do_sub),
      .dig_o  (raw_res[g*W +: W]),
      .cout   (chain[g+1])
    );
  end

  always_comb begin
    result     = active ? raw_res : '0;
    carry_flag = active & chain[NDIG];
  end

  always_comb begin
    if (mode == 2'd3) begin
      // R5
      idle_zero_chk: assert (result == '0 && carry_flag == 1'b0);
    end
  end
endmodule

// File: tb/tb_bcd_addsub2.sv
`timescale 1ns/1ps
module tb_bcd_addsub2;
  logic clk = 1'b0;
  logic [7:0] opnd_x = '0, opnd_y = '0;
  logic [1:0] mode = 2'd3;
  logic [7:0] result;
  logic       carry_flag;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_addsub2 dut (
    .opnd_x(opnd_x), .opnd_y(opnd_y), .mode(mode),
    .result(result), .carry_flag(carry_flag)
  );

  function automatic logic [7:0] to_bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic void model(int x, int y, int m, output logic [7:0] r, output logic f, output string tag);
    int v;
    f = 1'b0; r = '0; tag = "R5";
    case (m)
      0: begin v = x + y; f = (v >= 100); if (f) v -= 100; r = to_bcd(v); tag = "R1"; end
      1: begin v = x - y; f = (v < 0); if (f) v += 100; r = to_bcd(v); tag = f ? "R3" : "R2"; end
      2: begin v = y - x; f = (v < 0); if (f) v += 100; r = to_bcd(v); tag = "R4"; end
      default: ;
    endcase
  endfunction

  task automatic apply(int x, int y, int m, string force_tag);
    logic [7:0] er; logic ef; string tag;
    @(posedge clk);
    opnd_x = to_bcd(x); opnd_y = to_bcd(y); mode = 2'(m);
    @(negedge clk);
    model(x, y, m, er, ef, tag);
    if (force_tag != "") tag = force_tag;
    n_vec++;
    if (result !== er || carry_flag !== ef) begin
      n_bad++;
      $display("FAIL %s x=%0d y=%0d mode=%0d: result=%h flag=%b expected result=%h flag=%b",
               tag, x, y, m, result, carry_flag, er, ef);
    end
  endtask

  initial begin
    void'($urandom(32'h1d2c3b4a));
    // reset state: reserved mode with zero operands
    apply(0, 0, 3, "R5");
    // directed corners
    apply(37, 5, 0, "R6");   // result 8'h42
    apply(95, 5, 0, "R7");   // 00, flag 1
    apply(10, 1, 1, "R7");   // 09
    apply(0, 1, 1, "R7");    // 99, flag 1
    apply(99, 99, 0, "R1");  // 98, flag 1
    apply(1, 0, 2, "R4");    // 99, flag 1
    apply(99, 99, 3, "R5");
    // every legal pair in every operating mode
    for (int x = 0; x < 100; x++)
      for (int y = 0; y < 100; y++)
        for (int m = 0; m < 3; m++)
          apply(x, y, m, "");
    // random mix including the reserved code
    for (int k = 0; k < 2000; k++)
      apply(int'($urandom_range(99)), int'($urandom_range(99)), int'($urandom_range(3)), "");
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule